// File: doc/BRIEF.md
# Tearing-Effect Sync Detector

This block watches one tearing-effect line coming back from a display panel. Horizontal and vertical sync arrive on that same wire and differ only in pulse length. The block measures each pulse in ticks of a divided timing clock and compares the length against two programmed thresholds. A pulse long enough to be vertical sync starts a new frame. A shorter pulse that still clears the horizontal threshold counts as one display line.

From this frame and line tracking, the block produces a single active-low match pulse. The pulse is raised either at every vertical sync, or when the line count reaches a programmed target inside the current frame. A downstream edge-sensitive interrupt or transfer starter uses the falling edge of that pulse to release a frame update that is waiting. Glitches shorter than the horizontal threshold are dropped. Each sync type can be configured as active-low on its own.

Top module: `te_sync_detector`

## Requirements
- R1: After reset `match_n` is high and stays high until a qualifying sync event has been seen.
- R2: A pulse lasting at least (`vs_code`+1)*8 ticks is vertical sync. At the end of that pulse the line count returns to 0.
- R3: A pulse lasting at least `hs_code`+1 ticks and fewer than the vertical threshold adds one to the line count. Shorter pulses have no effect.
- R4: With `sync_mode` = 3, every vertical sync produces one match.
- R5: With `sync_mode` = 2, a match is produced when the line count becomes equal to `target_line`. A target of 0 matches at vertical sync.
- R6: With `sync_mode` set to 0 or 1, or with `tear_en` low, `match_n` stays high.
- R7: At most one match is produced per frame. The line count saturates at 2047 and never wraps.
- R8: When `hs_invert` or `vs_invert` is set, a low level on `te_in` is the active level for that sync type.
- R9: Pulse length is counted only on cycles where `tick_en` is high.
- R10: Each match drives `match_n` low for exactly one clock cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Marks the cycles that count as one measurement tick |
| te_in | input | 1 | Raw tearing-effect input from the panel |
| tear_en | input | 1 | Global enable for matching |
| sync_mode | input | 2 | 0 off, 1 reserved (off), 2 line match, 3 vertical-only match |
| target_line | input | 11 | Line number to match in mode 2 |
| vs_code | input | 9 | Vertical threshold, ticks = (code+1)*8 |
| hs_code | input | 3 | Horizontal threshold, ticks = code+1 |
| hs_invert | input | 1 | Horizontal sync is active low |
| vs_invert | input | 1 | Vertical sync is active low |
| match_n | output | 1 | Active-low one-cycle match pulse |

## Verification
The assertions assume that the configuration inputs stay stable while a pulse is being measured, and that the vertical threshold is larger than the horizontal one. The stimulus changes mode, target, thresholds and polarity only between frames, on idle input, and keeps the vertical threshold at 32 ticks against a horizontal threshold of 2. Each glitch and each boundary pulse sits exactly one tick on either side of a threshold. A polarity change can leave a short transient pulse behind. That pulse is always followed by a fresh vertical sync before any match is expected.

// File: rtl/te_sync_pkg.sv
package te_sync_pkg;
    typedef enum logic [1:0] {
        TE_MODE_OFF   = 2'd0,
        TE_MODE_RSVD  = 2'd1,
        TE_MODE_LINE  = 2'd2,
        TE_MODE_FRAME = 2'd3
    } te_mode_e;
endpackage

// File: rtl/te_input_sync.sv
module te_input_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[STAGES-2:0], din};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign dout = sh_q[STAGES-1];
endmodule

// File: rtl/te_pulse_meter.sv
module te_pulse_meter #(
    parameter int CNT_W = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic             level,
    output logic             done,
    output logic [CNT_W-1:0] width
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic             lvl;
        logic [CNT_W-1:0] cnt;
        logic             done;
        logic [CNT_W-1:0] width;
    } meter_t;

    meter_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        st_d.lvl  = level;
        if (level) begin
            if (tick_en && st_q.cnt != CNT_MAX) st_d.cnt = st_q.cnt + 1'b1;
        end else begin
            if (st_q.lvl) begin
                st_d.done  = 1'b1;
                st_d.width = st_q.cnt;
            end
            st_d.cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign done  = st_q.done;
    assign width = st_q.width;

    // R9: a cycle without a tick never advances the running count
    a_r9_tick_gates_count: assert property (@(posedge clk) disable iff (!rst_n)
        (level && st_q.lvl && !tick_en) |=> (st_q.cnt == $past(st_q.cnt)) || !st_q.lvl);
endmodule

// File: rtl/te_line_tracker.sv
module te_line_tracker
    import te_sync_pkg::*;
#(
    parameter int CNT_W  = 13,
    parameter int LINE_W = 11,
    parameter int VS_W   = 9,
    parameter int HS_W   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hs_done,
    input  logic [CNT_W-1:0]  hs_width,
    input  logic              vs_done,
    input  logic [CNT_W-1:0]  vs_width,
    input  logic [VS_W-1:0]   vs_code,
    input  logic [HS_W-1:0]   hs_code,
    input  te_mode_e          mode,
    input  logic [LINE_W-1:0] target_line,
    input  logic              tear_en,
    output logic              match_n
);
    localparam logic [LINE_W-1:0] LINE_MAX = '1;

    typedef struct packed {
        logic [LINE_W-1:0] line;
        logic              fdone;
        logic              match_n;
    } trk_t;

    trk_t st_d, st_q;
    logic [CNT_W-1:0] vs_ticks, hs_ticks;
    logic vs_evt, hs_evt, hit;

    always_comb begin
        vs_ticks = CNT_W'({1'b0, vs_code} + 1'b1) << 3;
        hs_ticks = CNT_W'(hs_code) + 1'b1;
        vs_evt   = vs_done && (vs_width >= vs_ticks);
        hs_evt   = hs_done && (hs_width >= hs_ticks) && (hs_width < vs_ticks) && !vs_evt;

        st_d         = st_q;
        st_d.match_n = 1'b1;
        if (vs_evt) begin
            st_d.line  = '0;
            st_d.fdone = 1'b0;
        end else if (hs_evt && st_q.line != LINE_MAX) begin
            st_d.line = st_q.line + 1'b1;
        end

        hit = 1'b0;
        case (mode)
            TE_MODE_FRAME: hit = vs_evt;
            TE_MODE_LINE:  hit = (vs_evt || hs_evt) && (st_d.line == target_line);
            default:       hit = 1'b0;
        endcase

        if (tear_en && hit && !st_d.fdone) begin
            st_d.match_n = 1'b0;
            st_d.fdone   = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{line: '0, fdone: 1'b0, match_n: 1'b1};
        else        st_q <= st_d;
    end

    assign match_n = st_q.match_n;

    a_r10_single_low: assert property (@(posedge clk) disable iff (!rst_n)
        !match_n |=> match_n);
    a_r7_no_second_match: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.fdone && !vs_done) |=> match_n);
    a_r7_line_saturates: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.line == LINE_MAX && !vs_done) |=> st_q.line == LINE_MAX);
    a_r2_vs_restarts_frame: assert property (@(posedge clk) disable iff (!rst_n)
        (vs_done && vs_width >= vs_ticks) |=> (st_q.line == '0));
    a_r6_enable_gate: assert property (@(posedge clk) disable iff (!rst_n)
        !tear_en |=> match_n);
endmodule

// File: rtl/te_sync_detector.sv
module te_sync_detector
    import te_sync_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int LINE_W      = 11,
    parameter int VS_W        = 9,
    parameter int HS_W        = 3,
    localparam int CNT_W      = VS_W + 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              te_in,
    input  logic              tear_en,
    input  logic [1:0]        sync_mode,
    input  logic [LINE_W-1:0] target_line,
    input  logic [VS_W-1:0]   vs_code,
    input  logic [HS_W-1:0]   hs_code,
    input  logic              hs_invert,
    input  logic              vs_invert,
    output logic              match_n
);
    logic             te_s;
    logic [1:0]       lvl;
    logic [1:0]       done;
    logic [CNT_W-1:0] width [2];

    te_input_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk(clk), .rst_n(rst_n), .din(te_in), .dout(te_s)
    );

    assign lvl[0] = te_s ^ hs_invert;
    assign lvl[1] = te_s ^ vs_invert;

    for (genvar g = 0; g < 2; g++) begin : g_meter
        te_pulse_meter #(.CNT_W(CNT_W)) meter_i (
            .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .level(lvl[g]),
            .done(done[g]), .width(width[g])
        );
    end

    te_line_tracker #(
        .CNT_W(CNT_W), .LINE_W(LINE_W), .VS_W(VS_W), .HS_W(HS_W)
    ) trk_i (
        .clk(clk), .rst_n(rst_n),
        .hs_done(done[0]), .hs_width(width[0]),
        .vs_done(done[1]), .vs_width(width[1]),
        .vs_code(vs_code), .hs_code(hs_code),
        .mode(te_mode_e'(sync_mode)), .target_line(target_line),
        .tear_en(tear_en), .match_n(match_n)
    );

    a_r6_mode_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_mode == 2'd0 || sync_mode == 2'd1) |=> match_n);
endmodule

// File: tb/te_sync_detector_tb.sv
module te_sync_detector_tb_top;
    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic [1:0]  mode;
        logic [10:0] tgt;
        logic [11:0] nl;
        logic [1:0]  exp_m;
        logic [11:0] exp_line;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{2'd3, 11'd0, 12'd5, 2'd1, 12'd0},
        '{2'd2, 11'd3, 12'd5, 2'd1, 12'd3},
        '{2'd2, 11'd0, 12'd4, 2'd1, 12'd0},
        '{2'd2, 11'd6, 12'd4, 2'd0, 12'd0},
        '{2'd0, 11'd2, 12'd4, 2'd0, 12'd0},
        '{2'd1, 11'd2, 12'd4, 2'd0, 12'd0},
        '{2'd2, 11'd1, 12'd1, 2'd1, 12'd1},
        '{2'd2, 11'd4, 12'd4, 2'd1, 12'd4}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick_en = 1'b1;
    logic te_in = 1'b0;
    logic tear_en = 1'b1;
    logic [1:0] sync_mode = 2'd0;
    logic [10:0] target_line = '0;
    logic [8:0] vs_code = 9'd3;
    logic [2:0] hs_code = 3'd1;
    logic hs_invert = 1'b0;
    logic vs_invert = 1'b0;
    logic match_n;

    logic idle = 1'b0;
    logic half_tick = 1'b0;
    int checks = 0, fails = 0;
    int match_cnt = 0, match_line = -1, double_low = 0, bench_line = 0;
    logic prev_low = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    te_sync_detector dut_i (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .te_in(te_in),
        .tear_en(tear_en), .sync_mode(sync_mode), .target_line(target_line),
        .vs_code(vs_code), .hs_code(hs_code), .hs_invert(hs_invert),
        .vs_invert(vs_invert), .match_n(match_n)
    );

    always @(negedge clk) begin
        tick_en <= half_tick ? ~tick_en : 1'b1;
        if (!rst_n) prev_low = 1'b0;
        else begin
            if (!match_n) begin
                match_cnt++;
                match_line = bench_line;
                if (prev_low) double_low++;
            end
            prev_low = !match_n;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic gap(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic drive_pulse(input int w);
        te_in = ~idle;
        repeat (w) @(negedge clk);
        te_in = idle;
    endtask

    task automatic send_v(input int w);
        drive_pulse(w);
        bench_line = 0;
        gap(12);
    endtask

    task automatic send_h();
        drive_pulse(4);
        if (bench_line < 2047) bench_line++;
        gap(8);
    endtask

    task automatic run_frame(input int nl);
        send_v(40);
        for (int i = 0; i < nl; i++) send_h();
        gap(8);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        int base;
        gap(3);
        // R1: reset state
        chk(match_n === 1'b1, "R1 reset", int'(match_n), 1);
        rst_n = 1'b1;
        gap(10);
        chk(match_n === 1'b1 && match_cnt == 0, "R1 idle", match_cnt, 0);

        for (int v = 0; v < 8; v++) begin
            sync_mode   = VECS[v].mode;
            target_line = VECS[v].tgt;
            base = match_cnt;
            run_frame(int'(VECS[v].nl));
            if (VECS[v].mode == 2'd3)
                chk(match_cnt - base == int'(VECS[v].exp_m), "R4 frame match", match_cnt - base, int'(VECS[v].exp_m));
            else if (VECS[v].mode == 2'd2)
                chk(match_cnt - base == int'(VECS[v].exp_m), "R5 line match", match_cnt - base, int'(VECS[v].exp_m));
            else
                chk(match_cnt - base == 0, "R6 mode off", match_cnt - base, 0);
            if (VECS[v].exp_m != 0)
                chk(match_line == int'(VECS[v].exp_line), "R5 match line", match_line, int'(VECS[v].exp_line));
        end

        // R4: consecutive frames each match
        sync_mode = 2'd3;
        base = match_cnt;
        run_frame(2);
        run_frame(2);
        chk(match_cnt - base == 2, "R4 two frames", match_cnt - base, 2);

        // R6: global enable low
        tear_en = 1'b0;
        base = match_cnt;
        run_frame(3);
        chk(match_cnt - base == 0, "R6 enable low", match_cnt - base, 0);
        tear_en = 1'b1;

        // R3: glitch below horizontal threshold ignored
        sync_mode = 2'd2;
        target_line = 11'd2;
        base = match_cnt;
        send_v(40);
        send_h();
        drive_pulse(1);
        gap(10);
        chk(match_cnt - base == 0, "R3 glitch ignored", match_cnt - base, 0);
        send_h();
        gap(4);
        chk(match_cnt - base == 1 && match_line == 2, "R3 line after glitch", match_line, 2);

        // R2/R3: vertical threshold boundary (32 ticks)
        sync_mode = 2'd3;
        base = match_cnt;
        drive_pulse(31);
        gap(12);
        chk(match_cnt - base == 0, "R3 31 ticks is line", match_cnt - base, 0);
        drive_pulse(32);
        gap(12);
        chk(match_cnt - base == 1, "R2 32 ticks is vertical", match_cnt - base, 1);

        // R2: vertical restarts the count in line mode
        sync_mode = 2'd2;
        target_line = 11'd1;
        base = match_cnt;
        run_frame(1);
        run_frame(1);
        chk(match_cnt - base == 2, "R2 count restarts", match_cnt - base, 2);

        // R8: inverted polarity
        sync_mode = 2'd0;
        hs_invert = 1'b1;
        vs_invert = 1'b1;
        idle = 1'b1;
        te_in = 1'b1;
        gap(12);
        sync_mode = 2'd3;
        base = match_cnt;
        send_v(40);
        chk(match_cnt - base == 1, "R8 low vertical", match_cnt - base, 1);
        sync_mode = 2'd2;
        target_line = 11'd2;
        base = match_cnt;
        run_frame(3);
        chk(match_cnt - base == 1 && match_line == 2, "R8 low lines", match_line, 2);
        sync_mode = 2'd0;
        hs_invert = 1'b0;
        vs_invert = 1'b0;
        idle = 1'b0;
        te_in = 1'b0;
        gap(12);

        // R9: ticks only on tick_en cycles
        half_tick = 1'b1;
        sync_mode = 2'd3;
        base = match_cnt;
        drive_pulse(40);
        gap(12);
        chk(match_cnt - base == 0, "R9 half rate short", match_cnt - base, 0);
        drive_pulse(70);
        gap(12);
        chk(match_cnt - base == 1, "R9 half rate long", match_cnt - base, 1);
        half_tick = 1'b0;
        gap(4);

        // R7: saturation and single match per frame
        sync_mode = 2'd2;
        target_line = 11'd2047;
        base = match_cnt;
        run_frame(2049);
        chk(match_cnt - base == 1, "R7 one match at saturation", match_cnt - base, 1);
        chk(match_line == 2047, "R7 saturated line", match_line, 2047);
        base = match_cnt;
        target_line = 11'd2;
        run_frame(4);
        chk(match_cnt - base == 1 && match_line == 2, "R7 no wrap after reset", match_line, 2);

        // R10: one-cycle pulses throughout
        chk(double_low == 0, "R10 single cycle", double_low, 0);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule